// File: doc/BRIEF.md
# BCH8 Error Location Unpacker and Sector Bit Corrector

After a 512-byte sector has been read from flash, a separate decoder reports how many bit errors it found and where they are. This block takes that report and repairs the sector in place. The report is one 32-bit status word and three 32-bit result words. Up to eight 13-bit error positions are packed across the three result words and the upper status byte, and several positions straddle a word boundary. The block unpacks the positions and inverts the two low bits of each one, which is how the decoder encodes them. It then flips each addressed bit in the sector RAM through a byte-wide read-modify-write port.

A caller pulses `start` and holds the status and result words on the inputs. The block waits until the status word says the result is ready, and only then samples the words. It walks the reported slots in order. A position that lies beyond the sector's data bits is skipped without touching the RAM. When the walk is finished, the block raises a one-cycle `done` pulse together with the number of bits it flipped. If the decoder reported more errors than it can locate, the block instead raises an uncorrectable flag and leaves the RAM alone.

Top module: `bch_fixup`

## Requirements
- R1: While reset is held and after it is released, `done`, `ram_rd_en`, `ram_wr_en`, `fix_count` and `uncorrectable` are all 0.
- R2: After `start`, the block waits until status bit 15 (ready) is 1, and it samples all four words in a cycle where that bit is 1. While it waits, there is no RAM access and no `done`.
- R3: The error count is status bits 13:10. A count of 0 ends the operation with `fix_count` = 0, `uncorrectable` = 0 and no RAM access.
- R4: A count of 9 to 15 ends the operation with `uncorrectable` = 1, `fix_count` = 0 and no RAM access.
- R5: The 104-bit result is {status[23:16], word3, word2, word1}, with word1 as the least significant. Slot k holds result bits 13k+12 down to 13k, so slot 2 joins word2[6:0] to word1[31:26], slot 4 joins word3[0] to word2[31:20], and slot 7 joins status[23:16] to word3[31:27].
- R6: Before a slot is used, bits 0 and 1 of its value are inverted. The result is the bit position p.
- R7: A position p that is not below the sector's data-bit count (8 × SECT_BYTES) is skipped without a RAM access. It still uses up one of the counted slots.
- R8: A position p in range is applied by reading byte p>>3 and then, in the next cycle, writing the same byte with bit p[2:0] inverted. The RAM returns read data one cycle after `ram_rd_en`.
- R9: `fix_count` is the number of positions actually applied. On a correctable result, `uncorrectable` is 0.
- R10: `done` is a one-cycle pulse. It is visible 2 cycles after `start` for a count of 0 or above 8. For a count of 1 to 8 it is visible 3 + skipped + 2 × applied cycles after `start`, plus one cycle for each wait cycle beyond the first.
- R11: Only slots 0 up to count−1 are used. Slots at or above the count have no effect on the RAM or on `fix_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to process a decoder report |
| stat_word | input | 32 | Status: bit 15 ready, bits 13:10 error count, bits 23:16 top of the result |
| res_w1 | input | 32 | Result bits 31:0 |
| res_w2 | input | 32 | Result bits 63:32 |
| res_w3 | input | 32 | Result bits 95:64 |
| ram_addr | output | ADDR_W (9) | Sector RAM byte address |
| ram_rd_en | output | 1 | Sector RAM read strobe |
| ram_rdata | input | 8 | Read data, valid one cycle after the read strobe |
| ram_wr_en | output | 1 | Sector RAM write strobe |
| ram_wdata | output | 8 | Write data (read byte with one bit inverted) |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Number of bits flipped, held until the next completion |
| uncorrectable | output | 1 | Too many errors reported, held until the next completion |

## Verification
The bench builds the block with SECT_BYTES = 64, which gives 512 data bits. As a result, a random 13-bit slot value lands out of range more often than in range, so the skip path and the flip path are both exercised heavily. It also lets the bench compare the whole RAM against its own model after every case. The sweep covers every error count from 0 to 15, and every slot as the last active one behind skipped slots. It also covers the edge positions 0, 3, 511 and 512, and ready flags that arrive late with stale words on the inputs beforehand.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  localparam int LOC_W   = 13;
  localparam int SLOTS   = 8;
  localparam int RES_W   = LOC_W * SLOTS;
  localparam int CNT_W   = 4;
  localparam int RDY_BIT = 15;
  localparam int CNT_LSB = 10;
  localparam int TOP_LSB = 16;
  localparam int TOP_W   = RES_W - 96;

  typedef logic [LOC_W-1:0] loc_t;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SCAN, S_WR} seq_t;

  function automatic loc_t pick_field(input logic [RES_W-1:0] v, input int k);
    return v[k*LOC_W +: LOC_W];
  endfunction

  function automatic loc_t fix_bits(input loc_t raw);
    return raw ^ loc_t'(3);
  endfunction

  function automatic logic hits_sector(input loc_t p, input int nbits);
    return int'(p) < nbits;
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] b);
    return 8'b1 << b;
  endfunction
endpackage

// File: rtl/bch_loc_unpack.sv
module bch_loc_unpack
  import bch_fix_pkg::*;
(
  input  logic [RES_W-1:0]  packed_res,
  output loc_t [SLOTS-1:0]  locs
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign locs[k] = fix_bits(pick_field(packed_res, k));
  end
endmodule

// File: rtl/bch_flip_seq.sv
module bch_flip_seq
  import bch_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  localparam int DATA_BITS = SECT_BYTES * 8,
  localparam int ADDR_W    = $clog2(SECT_BYTES),
  localparam int SEL_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rdy,
  input  logic [CNT_W-1:0]  err_cnt,
  input  loc_t [SLOTS-1:0]  locs,
  output logic              capture,
  output logic              waiting,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd_en,
  input  logic [7:0]        ram_rdata,
  output logic              ram_wr_en,
  output logic [7:0]        ram_wdata,
  output logic              done,
  output logic [CNT_W-1:0]  fix_count,
  output logic              uncorrectable
);
  seq_t              st_q;
  logic [CNT_W-1:0]  cnt_q, slot_q, fixed_q, count_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              done_q, uncorr_q;

  loc_t cur;
  logic slot_end, apply;

  assign cur       = locs[slot_q[SEL_W-1:0]];
  assign slot_end  = (slot_q == cnt_q);
  assign apply     = (st_q == S_SCAN) && !slot_end && hits_sector(cur, DATA_BITS);
  assign capture   = (st_q == S_WAIT) && rdy;
  assign waiting   = (st_q == S_WAIT) && !rdy;

  assign ram_rd_en = apply;
  assign ram_wr_en = (st_q == S_WR);
  assign ram_addr  = (st_q == S_WR) ? addr_q : cur[ADDR_W+2:3];
  assign ram_wdata = ram_rdata ^ bit_mask(bit_q);

  assign done          = done_q;
  assign fix_count     = count_q;
  assign uncorrectable = uncorr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      slot_q   <= '0;
      fixed_q  <= '0;
      count_q  <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
      uncorr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) st_q <= S_WAIT;
        S_WAIT: if (rdy) begin
          cnt_q   <= err_cnt;
          slot_q  <= '0;
          fixed_q <= '0;
          if (err_cnt == '0) begin
            done_q   <= 1'b1;
            count_q  <= '0;
            uncorr_q <= 1'b0;
            st_q     <= S_IDLE;
          end else if (err_cnt > CNT_W'(SLOTS)) begin
            done_q   <= 1'b1;
            count_q  <= '0;
            uncorr_q <= 1'b1;
            st_q     <= S_IDLE;
          end else begin
            st_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (slot_end) begin
            done_q   <= 1'b1;
            count_q  <= fixed_q;
            uncorr_q <= 1'b0;
            st_q     <= S_IDLE;
          end else if (apply) begin
            addr_q <= cur[ADDR_W+2:3];
            bit_q  <= cur[2:0];
            st_q   <= S_WR;
          end else begin
            slot_q <= slot_q + CNT_W'(1);
          end
        end
        S_WR: begin
          fixed_q <= fixed_q + CNT_W'(1);
          slot_q  <= slot_q + CNT_W'(1);
          st_q    <= S_SCAN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_fixup.sv
module bch_fixup
  import bch_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  localparam int ADDR_W    = $clog2(SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       stat_word,
  input  logic [31:0]       res_w1,
  input  logic [31:0]       res_w2,
  input  logic [31:0]       res_w3,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd_en,
  input  logic [7:0]        ram_rdata,
  output logic              ram_wr_en,
  output logic [7:0]        ram_wdata,
  output logic              done,
  output logic [3:0]        fix_count,
  output logic              uncorrectable
);
  logic [RES_W-1:0] res_q;
  loc_t [SLOTS-1:0] locs;
  logic             seq_capture, seq_waiting;

  wire unused_stat = ^{stat_word[31:24], stat_word[14], stat_word[9:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (seq_capture)
      res_q <= {stat_word[TOP_LSB +: TOP_W], res_w3, res_w2, res_w1};
  end

  bch_loc_unpack u_unpack (
    .packed_res (res_q),
    .locs       (locs)
  );

  bch_flip_seq #(.SECT_BYTES(SECT_BYTES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rdy           (stat_word[RDY_BIT]),
    .err_cnt       (stat_word[CNT_LSB +: CNT_W]),
    .locs          (locs),
    .capture       (seq_capture),
    .waiting       (seq_waiting),
    .ram_addr      (ram_addr),
    .ram_rd_en     (ram_rd_en),
    .ram_rdata     (ram_rdata),
    .ram_wr_en     (ram_wr_en),
    .ram_wdata     (ram_wdata),
    .done          (done),
    .fix_count     (fix_count),
    .uncorrectable (uncorrectable)
  );
endmodule

// File: rtl/bch_fixup_chk.sv
module bch_fixup_chk #(
  parameter int ADDR_W = 9,
  parameter int SLOTS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_rd_en,
  input logic [7:0]        ram_rdata,
  input logic              ram_wr_en,
  input logic [7:0]        ram_wdata,
  input logic              done,
  input logic [3:0]        fix_count,
  input logic              uncorrectable,
  input logic              waiting,
  input logic              capture
);
  a_r8_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> ram_wr_en && !ram_rd_en && ram_addr == $past(ram_addr));

  a_r8_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> $past(ram_rd_en));

  a_r8_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> $countones(ram_wdata ^ ram_rdata) == 1);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_uncorr_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> fix_count == 4'd0);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(fix_count) <= SLOTS);

  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !ram_rd_en && !ram_wr_en && !done);

  a_r2_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture && !waiting);
endmodule

bind bch_fixup bch_fixup_chk #(.ADDR_W(ADDR_W), .SLOTS(8)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ram_addr      (ram_addr),
  .ram_rd_en     (ram_rd_en),
  .ram_rdata     (ram_rdata),
  .ram_wr_en     (ram_wr_en),
  .ram_wdata     (ram_wdata),
  .done          (done),
  .fix_count     (fix_count),
  .uncorrectable (uncorrectable),
  .waiting       (seq_waiting),
  .capture       (seq_capture)
);

// File: tb/bch_fixup_test.sv
module bch_fixup_test;
  localparam int SB    = 64;
  localparam int DBITS = SB * 8;
  localparam int AW    = $clog2(SB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   stat_word = '0, res_w1 = '0, res_w2 = '0, res_w3 = '0;
  logic [AW-1:0] ram_addr;
  logic          ram_rd_en, ram_wr_en;
  logic [7:0]    ram_rdata, ram_wdata;
  logic          done, uncorrectable;
  logic [3:0]    fix_count;

  logic [7:0]  mem  [SB];
  logic [7:0]  refm [SB];
  logic [12:0] fld  [8];
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bch_fixup #(.SECT_BYTES(SB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stat_word(stat_word),
    .res_w1(res_w1), .res_w2(res_w2), .res_w3(res_w3),
    .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_rdata(ram_rdata),
    .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata), .done(done),
    .fix_count(fix_count), .uncorrectable(uncorrectable)
  );

  always @(posedge clk) begin
    if (ram_wr_en) mem[ram_addr] <= ram_wdata;
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // Builds the four words from fld[] bit by bit, runs one report, checks the outcome.
  task automatic run_case(input int n, input int hold, input string tag);
    logic [103:0] v;
    logic [31:0]  st, jw;
    int applied = 0, skips = 0, lat, k, mism;
    bit quiet = 1;
    bit exp_unc;
    v = '0;
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 13; b++) v[13*s + b] = fld[s][b];
    st = $urandom;
    st[15] = 1'b1;
    for (int b = 0; b < 4; b++) st[10+b] = n[b];
    for (int b = 0; b < 8; b++) st[16+b] = v[96+b];
    exp_unc = (n > 8);
    if (n == 0 || n > 8) lat = 2;
    else begin
      for (int s = 0; s < n; s++) begin
        int p;
        p = int'(fld[s] ^ 13'd3);
        if (p < DBITS) begin
          refm[p/8][p%8] = ~refm[p/8][p%8];
          applied++;
        end else skips++;
      end
      lat = 3 + skips + 2*applied;
    end
    if (hold > 1) lat = lat + hold - 1;
    jw = $urandom;
    start = 1'b1;
    if (hold > 0) begin
      stat_word = st ^ 32'h0000_8000 ^ 32'h00FF_3C00;
      res_w1 = ~v[31:0]; res_w2 = jw; res_w3 = ~v[95:64];
    end else begin
      stat_word = st; res_w1 = v[31:0]; res_w2 = v[63:32]; res_w3 = v[95:64];
    end
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (k < hold && (done || ram_rd_en || ram_wr_en)) quiet = 0;
      if (k == hold) begin
        stat_word = st; res_w1 = v[31:0]; res_w2 = v[63:32]; res_w3 = v[95:64];
      end
    end while (!done && k < 200);
    if (hold > 0) chk(quiet, {"R2 quiet wait ", tag}, int'(!quiet), 0);
    chk(k == lat, {"R10 latency ", tag}, k, lat);
    chk(fix_count == 4'(applied), {"R9 count ", tag}, int'(fix_count), applied);
    chk(uncorrectable == exp_unc, {"R3/R4 flag ", tag}, int'(uncorrectable), int'(exp_unc));
    mism = 0;
    for (int a = 0; a < SB; a++) if (mem[a] !== refm[a]) mism++;
    chk(mism == 0, {"R8 ram contents ", tag}, mism, 0);
    @(negedge clk);
    chk(!done, {"R10 pulse width ", tag}, int'(done), 0);
    chk(fix_count == 4'(applied) && uncorrectable == exp_unc, {"R9 held ", tag},
        int'(fix_count), applied);
  endtask

  task automatic fill_out_of_range();
    for (int s = 0; s < 8; s++) fld[s] = 13'(DBITS + ($urandom % (8192 - DBITS))) ^ 13'd3;
  endtask

  initial begin
    for (int a = 0; a < SB; a++) begin
      mem[a]  = 8'($urandom);
      refm[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    chk(!done && !ram_rd_en && !ram_wr_en && fix_count == 0 && !uncorrectable,
        "R1 in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !ram_rd_en && !ram_wr_en && fix_count == 0 && !uncorrectable,
        "R1 after reset", int'(fix_count), 0);

    // R3: count zero, in-range slots must not be applied
    for (int s = 0; s < 8; s++) fld[s] = 13'(s * 37);
    run_case(0, 0, "R3 zero");

    // R4: every count above eight
    for (int n = 9; n < 16; n++) begin
      for (int s = 0; s < 8; s++) fld[s] = 13'($urandom % DBITS);
      run_case(n, 0, "R4 too many");
    end

    // R6: raw 0 -> bit 3 of byte 0, raw 3 -> bit 0 of byte 0
    fill_out_of_range();
    fld[0] = 13'd0;
    run_case(1, 0, "R6 raw0");
    fld[0] = 13'd3;
    run_case(1, 0, "R6 raw3");

    // R7: edges of the data range (p=511 applied, p=512 and p=8191 skipped)
    fill_out_of_range();
    fld[0] = 13'd508; fld[1] = 13'd515; fld[2] = 13'h1FFC;
    run_case(3, 0, "R7 edges");

    // R5: each slot as the last active one behind skipped slots
    for (int s = 0; s < 8; s++) begin
      fill_out_of_range();
      fld[s] = 13'(($urandom % DBITS) ^ 3);
      run_case(s + 1, 0, "R5 slot");
    end

    // R11: unused slots carry in-range values
    for (int s = 0; s < 8; s++) fld[s] = 13'($urandom % DBITS);
    run_case(3, 0, "R11 unused slots");

    // R2: late ready with stale words beforehand
    for (int h = 1; h < 6; h++) begin
      for (int s = 0; s < 8; s++) fld[s] = 13'($urandom % DBITS);
      run_case(1 + (h % 8), h, "R2 late ready");
    end

    // Sweep: random counts and a mix of in-range and out-of-range positions
    for (int t = 0; t < 300; t++) begin
      for (int s = 0; s < 8; s++)
        fld[s] = ($urandom % 2) ? 13'($urandom) : 13'($urandom % DBITS);
      if (t % 5 == 0) fld[$urandom % 8] = fld[0];
      run_case(int'($urandom % 10), (t % 7 == 0) ? 3 : 0, "R8 sweep");
    end

    summary();
  end
endmodule